// File: doc/BRIEF.md
# Startup Reset Sequencer

This block produces the chip-wide active-low reset from a power-on indication and a shared, bidirectional reset pin. While supply power settles, the power-on input is low and the block holds its internal reset active. It also enables the weak pull-down on the reset pin. Once power is good, a counter in the master-clock domain times a fixed hold window. At the end of that window the reset and the pin are released together, so the rising edge on the pin marks the end of startup.

The pin driver is weak, so another device may pull the pin low. A two-stage synchronizer watches the pin level. When the pin stays low for a minimum run of consecutive master-clock cycles, the block drives the pin itself and repeats the full hold window, which returns every register to its default. Shorter low pulses are ignored.

On the clock edge that releases reset, the block samples three configuration straps (select, clock and data levels of the register port). It decodes them into three default configuration bits and holds them until the next release. The control and status pins are plain levels; the block has no streaming interface. The deassertion of the power-on input is assumed to be synchronous to the master clock.

Top module: `boot_reset_seq`

## Requirements
- R1: While `por_n` is low, `rst_n` is 0, `pin_drive_low` is 1 and all three configuration outputs are 0, independent of the clock.
- R2: After `por_n` rises, `rst_n` stays 0 for exactly `START_CYCLES` rising clock edges and becomes 1 on the `START_CYCLES`-th edge. `pin_drive_low` is 1 exactly while `rst_n` is 0.
- R3: While released, if `pin_in` is low for `LOW_MIN` or more consecutive rising edges, `rst_n` falls on rising edge `LOW_MIN+2`, counted from the first edge at which the pin is low. The two extra edges are the synchronizer delay.
- R4: While released, a low pulse on `pin_in` that lasts fewer than `LOW_MIN` rising edges leaves `rst_n` at 1 and the configuration outputs unchanged.
- R5: After an externally triggered reset, `rst_n` is held 0 for a full `START_CYCLES` edges again before it returns to 1.
- R6: On the edge that raises `rst_n`, the straps are captured as follows. `strap_in[2]` is the select level, and `cfg_div2` takes its inverse. `strap_in[1]` is the clock level, and `cfg_short_sync` takes its inverse. `strap_in[0]` is the data level, and `cfg_gain20` takes it unchanged.
- R7: At every other edge the configuration outputs keep their value, whatever `strap_in` does, including during the hold window of a re-initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-good from the analog detector, low while supply settles (asynchronous assert) |
| pin_in | input | 1 | Level read back from the shared reset pin |
| strap_in | input | 3 | Strap levels: [2] select, [1] clock, [0] data |
| rst_n | output | 1 | Chip-wide active-low reset |
| pin_drive_low | output | 1 | Enable of the weak pull-down on the reset pin |
| cfg_div2 | output | 1 | Captured default: master clock divided by two |
| cfg_short_sync | output | 1 | Captured default: short frame-sync protocol |
| cfg_gain20 | output | 1 | Captured default: high preamplifier gain |

## Verification
The bench builds the block with `START_CYCLES = 24` and `LOW_MIN = 5`, instead of a hold window of two million cycles. With these values every cycle of the hold window can be checked, and so can the exact edge at which the pin is released. Every external pulse length from one cycle up to just past the threshold is swept. All eight strap combinations are captured through a re-initialization each, which exercises every decode polarity at every release.

// File: rtl/boot_reset_pkg.sv
package boot_reset_pkg;

  localparam int STRAP_W   = 3;
  localparam int STRAP_SEL = 2;
  localparam int STRAP_CLK = 1;
  localparam int STRAP_DAT = 0;

  typedef struct packed {
    logic div2;
    logic short_sync;
    logic gain20;
  } boot_cfg_t;

  function automatic boot_cfg_t decode_straps(input logic [STRAP_W-1:0] s);
    boot_cfg_t c;
    c.div2       = ~s[STRAP_SEL];
    c.short_sync = ~s[STRAP_CLK];
    c.gain20     =  s[STRAP_DAT];
    return c;
  endfunction

endpackage

// File: rtl/brs_pin_sync.sv
module brs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)  chain[g] <= 1'b1;
        else if (clr) chain[g] <= 1'b1;
        else          chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/brs_low_detect.sv
module brs_low_detect #(
  parameter int LOW_MIN = 32
) (
  input  logic clk,
  input  logic arst_n,
  input  logic armed,
  input  logic pin_s,
  output logic fire
);
  localparam int LW = $clog2(LOW_MIN);
  localparam logic [LW-1:0] LAST = LW'(LOW_MIN - 1);

  logic [LW-1:0] run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)               run <= '0;
    else if (!armed || pin_s)  run <= '0;
    else if (run != LAST)      run <= run + 1'b1;
  end

  assign fire = armed && !pin_s && (run == LAST);
endmodule

// File: rtl/brs_hold_timer.sv
module brs_hold_timer #(
  parameter int COUNT = 2**21
) (
  input  logic clk,
  input  logic arst_n,
  input  logic restart,
  output logic released,
  output logic last
);
  localparam int CW = $clog2(COUNT);
  localparam logic [CW-1:0] TOP = CW'(COUNT - 1);

  logic [CW-1:0] cnt;

  assign last = !released && (cnt == TOP);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (restart) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (last) begin
      cnt      <= '0;
      released <= 1'b1;
    end else if (!released) begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brs_strap_latch.sv
module brs_strap_latch
  import boot_reset_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               capture,
  input  logic [STRAP_W-1:0] strap_in,
  output boot_cfg_t          cfg
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cfg <= '0;
    else if (capture) cfg <= decode_straps(strap_in);
  end
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_reset_pkg::*;
#(
  parameter int START_CYCLES = 2**21,
  parameter int LOW_MIN      = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               pin_in,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               rst_n,
  output logic               pin_drive_low,
  output logic               cfg_div2,
  output logic               cfg_short_sync,
  output logic               cfg_gain20
);
  logic      pin_s;
  logic      fire;
  logic      released;
  logic      last;
  boot_cfg_t cfg;

  brs_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .arst_n(por_n), .clr(!released), .d(pin_in), .q(pin_s)
  );

  brs_low_detect #(.LOW_MIN(LOW_MIN)) i_detect (
    .clk(clk), .arst_n(por_n), .armed(released), .pin_s(pin_s), .fire(fire)
  );

  brs_hold_timer #(.COUNT(START_CYCLES)) i_timer (
    .clk(clk), .arst_n(por_n), .restart(fire), .released(released), .last(last)
  );

  brs_strap_latch i_straps (
    .clk(clk), .arst_n(por_n), .capture(last), .strap_in(strap_in), .cfg(cfg)
  );

  assign rst_n          = released;
  assign pin_drive_low  = !released;
  assign cfg_div2       = cfg.div2;
  assign cfg_short_sync = cfg.short_sync;
  assign cfg_gain20     = cfg.gain20;
endmodule

// File: rtl/boot_reset_seq_chk.sv
module boot_reset_seq_chk
  import boot_reset_pkg::*;
#(
  parameter int START_CYCLES = 2**21,
  parameter int LOW_MIN      = 32,
  parameter int SYNC_STAGES  = 2
) (
  input logic               clk,
  input logic               por_n,
  input logic               pin_in,
  input logic [STRAP_W-1:0] strap_in,
  input logic               rst_n,
  input logic               pin_drive_low,
  input logic               cfg_div2,
  input logic               cfg_short_sync,
  input logic               cfg_gain20
);
  localparam int HW = $clog2(START_CYCLES + 2);
  localparam int PW = $clog2(LOW_MIN + 1);

  logic [HW-1:0] held;
  logic [PW-1:0] plow;
  logic          seen;
  boot_cfg_t     cfg_o;

  assign cfg_o = '{div2: cfg_div2, short_sync: cfg_short_sync, gain20: cfg_gain20};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      held <= '0;
    else if (rst_n)                  held <= '0;
    else if (held != HW'(START_CYCLES + 1)) held <= held + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !rst_n) begin
      plow <= '0;
      seen <= 1'b0;
    end else if (pin_in) begin
      plow <= '0;
    end else begin
      if (plow != PW'(LOW_MIN)) plow <= plow + 1'b1;
      if (plow == PW'(LOW_MIN - 1)) seen <= 1'b1;
    end
  end

  // R1
  always @(negedge clk) begin
    if (!por_n) begin
      p_por_hold_r1: assert (!rst_n && pin_drive_low && cfg_o == '0);
    end
  end

  // R2 and R5: every release ends a hold of exactly START_CYCLES edges
  p_hold_len_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> held == HW'(START_CYCLES));

  p_fire_needs_low_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_n) |-> $past(seen));

  p_capture_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> cfg_o == decode_straps($past(strap_in)));

  p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!por_n)
    !$rose(rst_n) |-> $stable(cfg_o));
endmodule

bind boot_reset_seq boot_reset_seq_chk #(
  .START_CYCLES(START_CYCLES), .LOW_MIN(LOW_MIN), .SYNC_STAGES(SYNC_STAGES)
) i_chk (.*);

// File: tb/test_boot_reset_seq.sv
`timescale 1ns/1ps
module test_boot_reset_seq;
  localparam int S = 24;
  localparam int M = 5;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_low = 1'b0;
  logic [2:0] strap_in = 3'b000;
  logic       pin_in;
  logic       rst_n, pin_drive_low, cfg_div2, cfg_short_sync, cfg_gain20;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign pin_in = ~(pin_drive_low | ext_low);

  boot_reset_seq #(.START_CYCLES(S), .LOW_MIN(M)) i_boot_reset_seq (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .strap_in(strap_in),
    .rst_n(rst_n), .pin_drive_low(pin_drive_low), .cfg_div2(cfg_div2),
    .cfg_short_sync(cfg_short_sync), .cfg_gain20(cfg_gain20)
  );

  function automatic int exp_cfg(input logic [2:0] v);
    return ((1 - int'(v[2])) * 4) + ((1 - int'(v[1])) * 2) + int'(v[0]);
  endfunction

  function automatic int cfg_now();
    return int'({cfg_div2, cfg_short_sync, cfg_gain20});
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // pulse of L cycles starting now (called right after a negedge)
  task automatic pulse(input int L, input bit fire, input int cfg_before,
                       input int cfg_after);
    int last_k;
    bit stayed;
    last_k = fire ? (M + 2 + S) : (M + 4);
    stayed = 1'b1;
    ext_low = 1'b1;
    for (int k = 1; k <= last_k; k++) begin
      @(negedge clk);
      if (fire) begin
        if (k == M + 1)     chk("R3 still released", int'(rst_n), 1);
        if (k == M + 2)     chk("R3 reset on threshold", int'(rst_n), 0);
        if (k == M + 2)     chk("R2 pin driven after detect", int'(pin_drive_low), 1);
        if (k == M + 1 + S) chk("R5 held full window", int'(rst_n), 0);
        if (k == M + 1 + S) chk("R7 cfg held in recount", cfg_now(), cfg_before);
        if (k == M + 2 + S) chk("R5 released after recount", int'(rst_n), 1);
        if (k == M + 2 + S) chk("R6 cfg captured", cfg_now(), cfg_after);
      end else begin
        if (!rst_n) stayed = 1'b0;
        strap_in = strap_in + 3'd1;
      end
      if (k == L) ext_low = 1'b0;
    end
    if (!fire) begin
      chk("R4 short pulse ignored", int'(stayed), 1);
      chk("R7 cfg unchanged", cfg_now(), cfg_before);
    end
  endtask

  initial begin
    int cur;
    strap_in = 3'b101;
    repeat (3) @(negedge clk);
    chk("R1 reset held", int'(rst_n), 0);
    chk("R1 pin driven", int'(pin_drive_low), 1);
    chk("R1 cfg cleared", cfg_now(), 0);

    por_n = 1'b1;
    for (int k = 1; k <= S; k++) begin
      @(negedge clk);
      chk("R2 hold window", int'(rst_n), (k == S) ? 1 : 0);
      chk("R2 pin driver", int'(pin_drive_low), (k == S) ? 0 : 1);
    end
    cur = exp_cfg(3'b101);
    chk("R6 startup capture", cfg_now(), cur);
    strap_in = 3'b010;
    repeat (4) @(negedge clk);
    chk("R7 straps moved, cfg held", cfg_now(), cur);

    for (int L = 1; L < M; L++) begin
      pulse(L, 1'b0, cur, cur);
      repeat (3) @(negedge clk);
    end

    for (int v = 0; v < 8; v++) begin
      strap_in = 3'(v);
      pulse(M + (v % 3), 1'b1, cur, exp_cfg(3'(v)));
      cur = exp_cfg(3'(v));
      repeat (3) @(negedge clk);
    end

    #1 por_n = 1'b0;
    #1;
    chk("R1 async power-on reset", int'(rst_n), 0);
    chk("R1 cfg cleared again", cfg_now(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule